// File: doc/BRIEF.md
# Trimmed Square-Wave Generator

This block derives a 4096 Hz timebase from its raw input clock and turns it into one of four selectable square waves on a single output pin: 1 Hz, 512 Hz, 4096 Hz, or the input clock divided by eight. The two slow outputs come from a compensated divider. A signed 8-bit trim value nudges that divider by whole timebase ticks so that a crystal that runs fast or slow by up to 127 ppm can be corrected in 1 ppm steps. The 4096 Hz and clock/8 outputs are taken before the correction and never move.

Correction works on a window of `WINDOW` timebase ticks (one million by default). Within each window, as many correction events occur as the trim magnitude, spread evenly by a running accumulator. A positive trim makes the compensated divider advance by two on an event, so the slow outputs run faster. A negative trim makes it hold for one tick on an event, so they run slower. The output pin is gated by an enable and is switched between sources only at safe points, so that every high pulse on the pin is a complete high phase of its source.

The enable, select and trim inputs stand in for register fields and are sampled directly on the input clock.

Top module: `sqw_trim_gen`

## Requirements
- R1: The select input picks the source: 0 gives 1 Hz, 1 gives 512 Hz, 2 gives 4096 Hz and 3 gives the input clock divided by 8.
- R2: The output is low while reset is asserted. From the first clock edge after the enable is sampled low, the output stays low until the enable returns high.
- R3: One timebase tick occurs every `TB_DIV` input clocks, and the 4096 Hz output is high for `TB_DIV/2` clocks out of every `TB_DIV`.
- R4: The clock/8 output is high for 4 input clocks and low for 4 input clocks.
- R5: With a trim of zero, the compensated divider advances once on every tick. The 512 Hz output is then high for 4 ticks of every 8, and the 1 Hz output is high for 2048 ticks of every 4096.
- R6: With a positive trim t (bit 7 clear), the compensated divider advances by two on t ticks of every `WINDOW` and by one on all other ticks. On no tick does it hold.
- R7: With a negative trim (bit 7 set) of magnitude m, the compensated divider holds on m ticks of every `WINDOW` and advances by one on all other ticks. On no tick does it advance by two.
- R8: A trim of -128 (8'h80) acts exactly like -127.
- R9: The trim value has no effect on the 4096 Hz or clock/8 outputs.
- R10: A select change made while the output is high takes effect at the output's next falling edge. A select change made while the output is low takes effect at once. In both cases the first high pulse from the new source is one of its complete high phases.
- R11: After the enable rises, the output stays low until the selected source has been seen low. The output then rises only together with a rise of the source, so the first pulse is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Raw input clock that drives all dividers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Square-wave output enable |
| sel_i | input | 2 | Frequency select (0: 1 Hz, 1: 512 Hz, 2: 4096 Hz, 3: clock/8) |
| trim_i | input | 8 | Two's-complement ppm trim for the 1 Hz and 512 Hz outputs |
| sq_o | output | 1 | Gated square-wave output |

## Verification
The assertions check, on every cycle, the following rules: the spacing of timebase ticks, the allowed step sizes of the compensated divider for zero, positive and negative trim, the output being low after the enable falls, the active source being held steady through a high pulse, and the output rising only once the gate has been armed. The bench checks the rates that only show up over many ticks. It counts output edges across several correction windows to show the ppm skew for positive, negative and clamped trims, and to show that the fast sources are unaffected. It also measures the widths of the pulses around select changes and enable changes.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    SQW_SEL_1HZ   = 2'd0,
    SQW_SEL_512HZ = 2'd1,
    SQW_SEL_4KHZ  = 2'd2,
    SQW_SEL_DIV8  = 2'd3
  } sqw_sel_e;

  localparam int unsigned SQW_NUM_SRC = 4;

  // Magnitude of a two's-complement trim, with -128 folded onto -127.
  function automatic logic [6:0] trim_mag(input logic [7:0] t);
    logic [7:0] n;
    n = ~t + 8'd1;
    if (t == 8'h80) return 7'd127;
    if (t[7])       return n[6:0];
    return t[6:0];
  endfunction

  // Compensated-divider increment for one timebase tick.
  function automatic logic [1:0] trim_step(input logic corr, input logic neg);
    if (!corr) return 2'd1;
    if (neg)   return 2'd0;
    return 2'd2;
  endfunction

endpackage

// File: rtl/sqw_timebase.sv
module sqw_timebase #(
  parameter int unsigned TB_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic wave_4k_o,
  output logic wave_div8_o
);
  localparam int unsigned TB_W = (TB_DIV > 2) ? $clog2(TB_DIV) : 1;
  localparam int unsigned HALF = TB_DIV / 2;

  logic [TB_W-1:0] tb_cnt;
  logic [2:0]      d8_cnt;

  assign tick_o      = (tb_cnt == TB_W'(TB_DIV - 1));
  assign wave_4k_o   = (tb_cnt >= TB_W'(HALF));
  assign wave_div8_o = d8_cnt[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_cnt <= '0;
      d8_cnt <= '0;
    end else begin
      tb_cnt <= tick_o ? '0 : tb_cnt + TB_W'(1);
      d8_cnt <= d8_cnt + 3'd1;
    end
  end
endmodule

// File: rtl/sqw_trim_ctl.sv
module sqw_trim_ctl
  import sqw_pkg::*;
#(
  parameter int unsigned WINDOW = 1000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] trim_i,
  output logic [1:0] step_o
);
  localparam int unsigned ACC_W = $clog2(WINDOW + 128);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic             corr;

  always_comb begin
    acc_sum = acc + ACC_W'(trim_mag(trim_i));
    corr    = tick_i && (acc_sum >= ACC_W'(WINDOW));
    step_o  = tick_i ? trim_step(corr, trim_i[7]) : 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc <= '0;
    else if (tick_i) acc <= corr ? acc_sum - ACC_W'(WINDOW) : acc_sum;
  end
endmodule

// File: rtl/sqw_comp_div.sv
module sqw_comp_div #(
  parameter int unsigned HI_LOG2 = 12,
  parameter int unsigned LO_LOG2 = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] step_i,
  output logic       wave_1hz_o,
  output logic       wave_512_o
);
  logic [HI_LOG2-1:0] cnt;

  assign wave_1hz_o = cnt[HI_LOG2-1];
  assign wave_512_o = cnt[LO_LOG2-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else         cnt <= cnt + HI_LOG2'(step_i);
  end
endmodule

// File: rtl/sqw_out_gate.sv
module sqw_out_gate
  import sqw_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [1:0]             sel_i,
  input  logic [SQW_NUM_SRC-1:0] waves_i,
  output logic                   sq_o,
  output logic [1:0]             act_sel_o,
  output logic                   armed_o
);
  logic src;
  assign src = waves_i[act_sel_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_o      <= 1'b0;
      act_sel_o <= 2'd0;
      armed_o   <= 1'b0;
    end else if (!en_i) begin
      sq_o      <= 1'b0;
      armed_o   <= 1'b0;
      act_sel_o <= sel_i;
    end else if (sq_o) begin
      if (!src) begin
        sq_o <= 1'b0;
        if (sel_i != act_sel_o) begin
          act_sel_o <= sel_i;
          armed_o   <= 1'b0;
        end
      end
    end else if (sel_i != act_sel_o) begin
      act_sel_o <= sel_i;
      armed_o   <= 1'b0;
    end else if (!armed_o) begin
      armed_o <= !src;
    end else begin
      sq_o <= src;
    end
  end
endmodule

// File: rtl/sqw_trim_gen.sv
module sqw_trim_gen
  import sqw_pkg::*;
#(
  parameter int unsigned TB_DIV  = 8,
  parameter int unsigned WINDOW  = 1000000,
  parameter int unsigned HI_LOG2 = 12,
  parameter int unsigned LO_LOG2 = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic [7:0] trim_i,
  output logic       sq_o
);
  logic                   tick_w;
  logic [1:0]             step_w;
  logic [1:0]             act_sel_w;
  logic                   armed_w;
  logic                   w_4k, w_div8, w_1hz, w_512;
  logic [SQW_NUM_SRC-1:0] waves_w;

  sqw_timebase #(.TB_DIV(TB_DIV)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_w),
    .wave_4k_o(w_4k), .wave_div8_o(w_div8)
  );

  sqw_trim_ctl #(.WINDOW(WINDOW)) u_trim (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w),
    .trim_i(trim_i), .step_o(step_w)
  );

  sqw_comp_div #(.HI_LOG2(HI_LOG2), .LO_LOG2(LO_LOG2)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_w),
    .wave_1hz_o(w_1hz), .wave_512_o(w_512)
  );

  always_comb begin
    waves_w                = '0;
    waves_w[SQW_SEL_1HZ]   = w_1hz;
    waves_w[SQW_SEL_512HZ] = w_512;
    waves_w[SQW_SEL_4KHZ]  = w_4k;
    waves_w[SQW_SEL_DIV8]  = w_div8;
  end

  sqw_out_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sel_i(sel_i),
    .waves_i(waves_w), .sq_o(sq_o), .act_sel_o(act_sel_w), .armed_o(armed_w)
  );
endmodule

// File: rtl/sqw_trim_gen_chk.sv
module sqw_trim_gen_chk #(
  parameter int unsigned TB_DIV = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [7:0] trim_i,
  input logic       sq_o,
  input logic       tick_i,
  input logic [1:0] step_i,
  input logic [1:0] act_sel_i,
  input logic       armed_i
);
  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick_i) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 32'd1;
    end
  end

  a_r2_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sq_o);

  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && seen) |-> (gap == TB_DIV - 1));

  a_r5_zero_trim_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && trim_i == 8'd0) |-> (step_i == 2'd1));

  a_r6_pos_never_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !trim_i[7]) |-> (step_i != 2'd0));

  a_r7_neg_never_doubles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && trim_i[7]) |-> (step_i != 2'd2));

  a_r3_idle_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> (step_i == 2'd0));

  a_r10_sel_held_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sq_o) && sq_o) |-> $stable(act_sel_i));

  a_r11_rise_when_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sq_o) |-> ($past(armed_i) && $past(en_i)));
endmodule

bind sqw_trim_gen sqw_trim_gen_chk #(.TB_DIV(TB_DIV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .trim_i(trim_i), .sq_o(sq_o),
  .tick_i(tick_w), .step_i(step_w), .act_sel_i(act_sel_w), .armed_i(armed_w)
);

// File: tb/sqw_trim_gen_bench.sv
module sqw_trim_gen_bench;
  localparam int unsigned TB_DIV = 4;
  localparam int unsigned WIN    = 256;
  localparam int          TMO    = 40000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] trim = 8'd0;
  logic       sq;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  sqw_trim_gen #(.TB_DIV(TB_DIV), .WINDOW(WIN)) u_sqw_trim_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sel_i(sel), .trim_i(trim), .sq_o(sq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp);
    n_chk++;
    if (act < exp - 1 || act > exp + 1) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (+/-1)", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    int t = 0;
    while (sq !== 1'b0 && t < TMO) begin @(negedge clk); t++; end
    while (sq !== 1'b1 && t < TMO) begin @(negedge clk); t++; end
  endtask

  task automatic high_width(output int w);
    wait_rise();
    w = 0;
    while (sq === 1'b1 && w < TMO) begin w++; @(negedge clk); end
  endtask

  task automatic count_rises(input int n, output int c);
    logic prev = sq;
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sq && !prev) c++;
      prev = sq;
    end
  endtask

  task automatic t_reset();
    int highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sq) highs++; end
    check("R2 low in reset", highs, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (sq) highs++; end
    check("R2 low while disabled", highs, 0);
  endtask

  task automatic t_fast();
    int w, c;
    sel = 2'd3; en = 1'b1; trim = 8'd0;
    high_width(w); check("R4 R1 div8 high", w, 4);
    w = 0; while (sq === 1'b0 && w < TMO) begin w++; @(negedge clk); end
    check("R4 div8 low", w, 4);
    sel = 2'd2;
    high_width(w); check("R3 R1 4096 Hz high", w, TB_DIV / 2);
    count_rises(4000, c); check_near("R3 4096 Hz rate", c, 4000 / TB_DIV);
  endtask

  task automatic t_comp_zero();
    int w;
    trim = 8'd0; sel = 2'd1;
    high_width(w); check("R5 R1 512 Hz high", w, 4 * TB_DIV);
    high_width(w); check("R5 512 Hz high again", w, 4 * TB_DIV);
    sel = 2'd0;
    high_width(w); check("R5 R1 1 Hz high", w, 2048 * TB_DIV);
  endtask

  // Edges of the 512 Hz output over a number of whole windows:
  // (ticks + windows*skew) / 8.
  task automatic rate_512(input string req, input logic [7:0] t, input int wins, input int skew);
    int c;
    sel = 2'd1; trim = t;
    wait_rise();
    count_rises(wins * WIN * TB_DIV, c);
    check_near(req, c, (wins * WIN + wins * skew) / 8);
  endtask

  task automatic t_trim();
    rate_512("R5 zero trim rate", 8'd0, 8, 0);
    rate_512("R6 trim +20 rate", 8'd20, 8, 20);
    rate_512("R6 trim +127 rate", 8'd127, 8, 127);
    rate_512("R7 trim -20 rate", 8'hEC, 8, -20);
    rate_512("R8 trim -128 as -127", 8'h80, 16, -127);
  endtask

  task automatic t_fast_untrimmed();
    int c;
    trim = 8'd127; sel = 2'd2;
    wait_rise();
    count_rises(4000, c); check_near("R9 4096 Hz untrimmed", c, 4000 / TB_DIV);
    sel = 2'd3;
    wait_rise();
    count_rises(4000, c); check_near("R9 div8 untrimmed", c, 500);
    trim = 8'd0;
  endtask

  task automatic t_switch();
    int w;
    sel = 2'd3;
    wait_rise();
    w = 0;
    while (sq === 1'b1 && w < TMO) begin
      w++;
      if (w == 2) sel = 2'd1;
      @(negedge clk);
    end
    check("R10 switch deferred to fall", w, 4);
    high_width(w); check("R10 first pulse after switch", w, 4 * TB_DIV);
    wait_rise();
    while (sq === 1'b1) @(negedge clk);
    sel = 2'd2;
    high_width(w); check("R10 switch while low", w, TB_DIV / 2);
  endtask

  task automatic t_disable();
    int highs = 0;
    sel = 2'd0;
    wait_rise();
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 200; i++) begin if (sq) highs++; @(negedge clk); end
    check("R2 low after disable mid-pulse", highs, 0);
  endtask

  task automatic t_enable();
    int w;
    sel = 2'd1;
    for (int k = 0; k < 4; k++) begin
      en = 1'b0;
      repeat (5 + 7 * k) @(negedge clk);
      en = 1'b1;
      high_width(w);
      check("R11 full first pulse", w, 4 * TB_DIV);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..: actual 190000 cycles expected completion earlier");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fast();
    t_comp_zero();
    t_trim();
    t_fast_untrimmed();
    t_switch();
    t_disable();
    t_enable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule